// File: doc/BRIEF.md
# DRAM Controller with Refresh

This block sits between a processor-side request port and a DRAM whose address pins carry the row and the column one after the other. A request holds a full address, a read or write flag and write data. The controller latches the request and puts the upper address bits on the shared pins while it pulls the row strobe low. It then puts the lower bits on the same pins while it pulls the column strobe low. It holds both strobes for the data phase and then releases them for a precharge period. Read data comes back with a single-cycle completion pulse.

A free-running timer keeps refresh on schedule. When an interval has elapsed, the next idle slot runs a row-strobe-only cycle. That cycle drives an internal refresh row counter onto the pins, and the counter then steps to the next row. A two-bit status output tells the rest of the system whether the memory is idle, serving an access or refreshing.

Top module: `dramc_top`

## Requirements
- R1: The request address splits into a row field, its upper ROW_W bits, and a column field, its lower COL_W bits. The row field is on the shared pins (low bits) when the row strobe falls. The column field is on the pins while the column strobe is low.
- R2: For an access, the column strobe falls exactly T_ROW cycles after the row strobe falls. The column strobe is never low while the row strobe is high.
- R3: In an access, the row strobe stays low for T_ROW+T_COL+T_DATA cycles and the column strobe for T_COL+T_DATA cycles. After any cycle, the row strobe stays high for at least T_PRE cycles before it falls again.
- R4: During a write, the write strobe (active low) is low and the latched write data is driven for every cycle the column strobe is low. During a read, the write strobe stays high.
- R5: A refresh asserts only the row strobe, for T_ROW cycles, with the refresh row on the pins. The refresh row starts at 0 after reset and increments by one modulo 2^ROW_W after each refresh.
- R6: While no access intervenes, consecutive refresh row-strobe falls are exactly REF_INTERVAL cycles apart.
- R7: A refresh that is due when the controller is idle wins over a waiting request, so the next cycle is a refresh. An access that has started is never cut short.
- R8: `req_ready` is high only when the controller is idle and no refresh is due. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R9: `rsp_done` is high for exactly one cycle per accepted request. It rises T_ROW+T_COL+T_DATA+1 cycles after the cycle in which the request was taken. For a read, `rsp_rdata` then holds the data the DRAM returned for that address.
- R10: `status` encodes 2'b00 idle, 2'b01 access in progress (including its precharge) and 2'b10 refresh in progress (including its precharge).
- R11: During reset, all three strobes are high, `status` is idle, `rsp_done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Full word address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_wdata | output | DATA_W | Data to the DRAM |
| dram_rdata | input | DATA_W | Data from the DRAM |
| status | output | 2 | 00 idle, 01 access, 10 refresh |

## Verification
Single writes and reads use the address extremes 0x00 and 0xFF, two columns of one row and distinct rows. These separate a swapped or shifted row/column split, because a wrong field lands the data in another cell of the bench DRAM model and the read-back shows it. A long burst follows, with `req_valid` held high and writes interleaved with reads of the same addresses. In this burst, refreshes fall due while a request is waiting, which exercises the priority and the rule that an access is not interrupted. A long quiet stretch then runs refreshes back to back. It measures their spacing and walks the refresh row through its wrap from the top row to 0.

// File: rtl/dramc_pkg.sv
`timescale 1ns/1ps
package dramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_DATA = 3'd3,
    ST_PRE  = 3'd4
  } dram_state_e;

  typedef enum logic [1:0] {
    STAT_IDLE    = 2'b00,
    STAT_ACCESS  = 2'b01,
    STAT_REFRESH = 2'b10
  } dram_status_e;

  typedef enum logic [1:0] {
    SEL_ROW = 2'd0,
    SEL_COL = 2'd1,
    SEL_REF = 2'd2
  } pin_sel_e;

endpackage

// File: rtl/dramc_refresh_unit.sv
`timescale 1ns/1ps
module dramc_refresh_unit #(
  parameter int INTERVAL = 780,
  parameter int ROW_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  output logic             due,
  output logic [ROW_W-1:0] ref_row
);

  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;

  // next row after a refresh, wraps at the row count
  function automatic logic [ROW_W-1:0] step_row(input logic [ROW_W-1:0] r);
    return r + 1'b1;
  endfunction

  assign due     = (cnt_q == LAST);
  assign ref_row = row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (!due) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (advance) begin
      row_q <= step_row(row_q);
    end
  end

  assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_due_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !restart) |=> due);

  assert_row_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (row_q == ROW_W'($past(row_q) + 1'b1)));

  assert_row_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(row_q));

endmodule

// File: rtl/dramc_addr_mux.sv
`timescale 1ns/1ps
module dramc_addr_mux
  import dramc_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int PIN_W = 10
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [ROW_W-1:0]       ref_row,
  input  pin_sel_e               sel,
  output logic [PIN_W-1:0]       pins
);

  localparam int AW = ROW_W + COL_W;

  function automatic logic [ROW_W-1:0] row_part(input logic [AW-1:0] a);
    return a[AW-1 -: ROW_W];
  endfunction

  function automatic logic [COL_W-1:0] col_part(input logic [AW-1:0] a);
    return a[COL_W-1:0];
  endfunction

  always_comb begin
    pins = '0;
    unique case (sel)
      SEL_ROW: pins[ROW_W-1:0] = row_part(addr);
      SEL_COL: pins[COL_W-1:0] = col_part(addr);
      SEL_REF: pins[ROW_W-1:0] = ref_row;
      default: pins = '0;
    endcase
  end

endmodule

// File: rtl/dramc_fsm.sv
`timescale 1ns/1ps
module dramc_fsm
  import dramc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int T_ROW  = 3,
  parameter int T_COL  = 2,
  parameter int T_DATA = 1,
  parameter int T_PRE  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ref_due,
  input  logic [DATA_W-1:0] dram_rdata,
  output logic              req_ready,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output pin_sel_e          pin_sel,
  output logic              ref_start,
  output logic              ref_advance,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output dram_status_e      status
);

  localparam int T_A  = (T_ROW > T_COL) ? T_ROW : T_COL;
  localparam int T_B  = (T_DATA > T_PRE) ? T_DATA : T_PRE;
  localparam int TMAX = (T_A > T_B) ? T_A : T_B;
  localparam int PH_W = (TMAX > 1) ? $clog2(TMAX) : 1;

  dram_state_e       state_q;
  logic [PH_W-1:0]   ph_q;
  logic              is_ref_q;
  logic              we_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  // cycles each phase lasts
  function automatic int phase_len(input dram_state_e s);
    case (s)
      ST_ROW:  return T_ROW;
      ST_COL:  return T_COL;
      ST_DATA: return T_DATA;
      ST_PRE:  return T_PRE;
      default: return 1;
    endcase
  endfunction

  // phase order: a refresh skips the column and data phases
  function automatic dram_state_e next_state(input dram_state_e s, input logic refresh);
    case (s)
      ST_ROW:  return refresh ? ST_PRE : ST_COL;
      ST_COL:  return ST_DATA;
      ST_DATA: return ST_PRE;
      default: return ST_IDLE;
    endcase
  endfunction

  // named internal events
  logic phase_last;
  logic acc_start;
  logic in_row_phase;
  logic in_col_phase;

  assign phase_last   = (state_q != ST_IDLE) && (int'(ph_q) == phase_len(state_q) - 1);
  assign ref_start    = (state_q == ST_IDLE) && ref_due;
  assign acc_start    = (state_q == ST_IDLE) && !ref_due && req_valid;
  assign ref_advance  = (state_q == ST_ROW) && is_ref_q && phase_last;
  assign in_col_phase = (state_q == ST_COL) || (state_q == ST_DATA);
  assign in_row_phase = (state_q == ST_ROW) || in_col_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ph_q     <= '0;
      is_ref_q <= 1'b0;
      addr_q   <= '0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        ph_q <= '0;
        if (ref_start) begin
          state_q  <= ST_ROW;
          is_ref_q <= 1'b1;
        end else if (acc_start) begin
          state_q  <= ST_ROW;
          is_ref_q <= 1'b0;
          addr_q   <= req_addr;
          we_q     <= req_we;
          wdata_q  <= req_wdata;
        end
      end else if (phase_last) begin
        state_q <= next_state(state_q, is_ref_q);
        ph_q    <= '0;
        if (state_q == ST_DATA) begin
          done_q <= 1'b1;
          if (!we_q) rdata_q <= dram_rdata;
        end
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE) && !ref_due;
  assign ras_n     = !in_row_phase;
  assign cas_n     = !(in_col_phase && !is_ref_q);
  assign we_n      = !(in_col_phase && we_q && !is_ref_q);
  assign done      = done_q;
  assign rdata     = rdata_q;

  always_comb begin
    if (in_col_phase)  pin_sel = SEL_COL;
    else if (is_ref_q) pin_sel = SEL_REF;
    else               pin_sel = SEL_ROW;
  end

  always_comb begin
    if (state_q == ST_IDLE) status = STAT_IDLE;
    else if (is_ref_q)      status = STAT_REFRESH;
    else                    status = STAT_ACCESS;
  end

  assert_no_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(is_ref_q));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ref_no_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status == STAT_REFRESH) |-> cas_n);

  assert_due_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && ref_due) |=> (status == STAT_REFRESH));

  assert_take_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (status == STAT_ACCESS && !ras_n));

endmodule

// File: rtl/dramc_top.sv
`timescale 1ns/1ps
module dramc_top
  import dramc_pkg::*;
#(
  parameter int ROW_W        = 10,
  parameter int COL_W        = 10,
  parameter int DATA_W       = 16,
  parameter int T_ROW        = 3,
  parameter int T_COL        = 2,
  parameter int T_DATA       = 1,
  parameter int T_PRE        = 3,
  parameter int REF_INTERVAL = 780,
  localparam int ADDR_W      = ROW_W + COL_W,
  localparam int PIN_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [PIN_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_wdata,
  input  logic [DATA_W-1:0] dram_rdata,
  output logic [1:0]        status
);

  logic              ref_due;
  logic              ref_start;
  logic              ref_advance;
  logic [ROW_W-1:0]  ref_row;
  logic [ADDR_W-1:0] addr_q;
  pin_sel_e          pin_sel;
  dram_status_e      stat_e;

  dramc_refresh_unit #(
    .INTERVAL (REF_INTERVAL),
    .ROW_W    (ROW_W)
  ) u_refresh (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ref_start),
    .advance (ref_advance),
    .due     (ref_due),
    .ref_row (ref_row)
  );

  dramc_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .T_ROW  (T_ROW),
    .T_COL  (T_COL),
    .T_DATA (T_DATA),
    .T_PRE  (T_PRE)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_we      (req_we),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .ref_due     (ref_due),
    .dram_rdata  (dram_rdata),
    .req_ready   (req_ready),
    .addr_q      (addr_q),
    .wdata_q     (dram_wdata),
    .pin_sel     (pin_sel),
    .ref_start   (ref_start),
    .ref_advance (ref_advance),
    .ras_n       (dram_ras_n),
    .cas_n       (dram_cas_n),
    .we_n        (dram_we_n),
    .done        (rsp_done),
    .rdata       (rsp_rdata),
    .status      (stat_e)
  );

  dramc_addr_mux #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .PIN_W (PIN_W)
  ) u_mux (
    .addr    (addr_q),
    .ref_row (ref_row),
    .sel     (pin_sel),
    .pins    (dram_addr)
  );

  assign status = stat_e;

  assert_col_inside_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  assert_write_in_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> !dram_cas_n);

endmodule

// File: tb/tb_dramc_top.sv
`timescale 1ns/1ps
module tb_dramc_top;

  localparam int ROW_W = 4;
  localparam int COL_W = 4;
  localparam int DW    = 8;
  localparam int TR    = 2;
  localparam int TC    = 2;
  localparam int TD    = 1;
  localparam int TP    = 2;
  localparam int RI    = 40;
  localparam int AW    = ROW_W + COL_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [COL_W-1:0] dram_addr;
  logic          dram_ras_n, dram_cas_n, dram_we_n;
  logic [DW-1:0] dram_wdata;
  logic [DW-1:0] dram_rdata;
  logic [1:0]    status;

  always #4 clk = ~clk;

  dramc_top #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .T_ROW(TR), .T_COL(TC),
    .T_DATA(TD), .T_PRE(TP), .REF_INTERVAL(RI)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_wdata(dram_wdata), .dram_rdata(dram_rdata), .status(status)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench DRAM model and shadow copy
  logic [DW-1:0]    dmem   [0:(1<<AW)-1];
  logic [DW-1:0]    shadow [0:(1<<AW)-1];
  logic [ROW_W-1:0] row_l = '0;

  assign dram_rdata = dmem[{row_l, dram_addr}];

  typedef struct {
    bit            we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int            acc;
  } item_t;
  item_t sbq[$];

  // driver: called at a falling edge, returns at the falling edge after acceptance
  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    item_t it;
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (we) shadow[a] = d;
    it.we   = we;
    it.addr = a;
    it.data = we ? d : shadow[a];
    it.acc  = cyc;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 1'b0;
  endtask

  // monitor
  bit               p_ras = 1, p_cas = 1, p_done = 0;
  bit               cas_seen = 0, acc_since = 0, have_ref = 0, had_rise = 0;
  int               low_cnt = 0, cas_cnt = 0, high_cnt = 0, fall_cyc = 0, last_ref = 0;
  int               n_ref = 0, n_prio = 0;
  logic [1:0]       st_fall = 2'b00;
  logic [ROW_W-1:0] exp_ref = '0;
  bit               prio_pend = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prio_pend) begin
        chk(status == 2'b10, "R7 refresh before waiting request", status, 2);
        prio_pend = 0;
      end
      if (status == 2'b00 && req_valid && !req_ready) begin
        prio_pend = 1;
        n_prio++;
      end
      if (req_ready) chk(status == 2'b00, "R8 ready only when idle", status, 0);

      if (!dram_ras_n && p_ras) begin
        row_l = dram_addr[ROW_W-1:0];
        if (had_rise) chk(high_cnt >= TP, "R3 precharge length", high_cnt, TP);
        low_cnt = 0; cas_seen = 0; fall_cyc = cyc; st_fall = status;
      end
      if (!dram_ras_n) low_cnt++;
      else high_cnt++;

      if (!dram_cas_n) begin
        if (p_cas) begin
          cas_cnt = 0;
          chk(!dram_ras_n, "R2 column strobe with row strobe low", dram_ras_n, 0);
          chk(cyc - fall_cyc == TR, "R2 row-to-column delay", cyc - fall_cyc, TR);
          chk(status == 2'b01, "R10 access status", status, 1);
          if (sbq.size() > 0)
            chk({row_l, dram_addr} == sbq[0].addr, "R1 row/column split", {row_l, dram_addr}, sbq[0].addr);
          else chk(0, "R1 access without request", 1, 0);
        end
        cas_seen = 1;
        cas_cnt++;
        if (sbq.size() > 0) begin
          chk(dram_we_n == !sbq[0].we, "R4 write strobe", dram_we_n, !sbq[0].we);
          if (sbq[0].we) chk(dram_wdata == sbq[0].data, "R4 write data", dram_wdata, sbq[0].data);
        end
        if (!dram_we_n) dmem[{row_l, dram_addr}] = dram_wdata;
      end
      if (dram_cas_n && !p_cas)
        chk(cas_cnt == TC + TD, "R3 column strobe length", cas_cnt, TC + TD);

      if (dram_ras_n && !p_ras) begin
        had_rise = 1;
        high_cnt = 1;
        if (cas_seen) begin
          chk(low_cnt == TR + TC + TD, "R3 access row strobe length", low_cnt, TR + TC + TD);
          acc_since = 1;
        end else begin
          chk(low_cnt == TR, "R5 refresh row strobe length", low_cnt, TR);
          chk(row_l == exp_ref, "R5 refresh row", row_l, exp_ref);
          chk(st_fall == 2'b10, "R10 refresh status", st_fall, 2);
          if (have_ref && !acc_since)
            chk(fall_cyc - last_ref == RI, "R6 refresh spacing", fall_cyc - last_ref, RI);
          have_ref = 1; last_ref = fall_cyc; acc_since = 0;
          exp_ref = exp_ref + 1'b1;
          n_ref++;
        end
      end

      if (rsp_done) begin
        chk(!p_done, "R9 done lasts one cycle", p_done, 0);
        if (sbq.size() > 0) begin
          item_t it;
          it = sbq.pop_front();
          chk(cyc - it.acc == TR + TC + TD + 1, "R9 done latency", cyc - it.acc, TR + TC + TD + 1);
          if (!it.we) chk(rsp_rdata == it.data, "R9 read data", rsp_rdata, it.data);
        end else chk(0, "R9 done without request", 1, 0);
      end
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_done = rsp_done;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      dmem[i] = '0;
      shadow[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R11 strobes high in reset", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(status == 2'b00, "R11 idle status in reset", status, 0);
    chk(!rsp_done, "R11 no done in reset", rsp_done, 0);
    chk(req_ready, "R11 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 R9 single accesses at extremes and shared rows
    issue(1, 8'h00, 8'hA5); idle(); repeat (3) @(negedge clk);
    issue(1, 8'hFF, 8'h3C); idle(); repeat (3) @(negedge clk);
    issue(1, 8'h12, 8'h77);
    issue(1, 8'h13, 8'h88);
    issue(1, 8'h21, 8'h99); idle(); repeat (2) @(negedge clk);
    issue(0, 8'h00, 8'h00);
    issue(0, 8'hFF, 8'h00);
    issue(0, 8'h12, 8'h00);
    issue(0, 8'h13, 8'h00);
    issue(0, 8'h21, 8'h00); idle();
    repeat (10) @(negedge clk);

    // R7 back-to-back traffic so refreshes fall due with a request waiting
    for (int i = 0; i < 48; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 37 + 5);
      issue(1, a, DW'(i * 11 + 3));
      issue(0, a, 8'h00);
    end
    idle();

    // R5 R6 quiet stretch: back-to-back refreshes and row wrap
    repeat (18 * RI + 20) @(negedge clk);
    issue(0, 8'hFF, 8'h00);
    issue(0, AW'(47 * 37 + 5), 8'h00);
    idle();
    repeat (20) @(negedge clk);

    chk(sbq.size() == 0, "R9 every request completed", sbq.size(), 0);
    chk(n_prio > 0, "R7 refresh won over waiting request", n_prio, 1);
    chk(n_ref > (1 << ROW_W), "R5 refresh row wrapped", n_ref, (1 << ROW_W) + 1);
    finish_run();
  end

endmodule